// File: doc/BRIEF.md
# Interrupt Request Router with Priority

The router takes a set of level-sensitive maskable interrupt request lines. Each line has its own small configuration entry. The entry holds an enable flag, a 3-bit priority level and a target flag. The target flag sends the line either to the main CPU or to a coprocessor. Software-side logic writes one entry at a time through a simple write strobe with an index.

In every cycle the block runs two separate arbitrations in parallel, one for each target. The CPU arbitration considers only lines whose level is above the CPU's current interrupt priority mask. The coprocessor arbitration ignores that mask. When two lines share a level, the line with the lower index wins.

The CPU winner is presented as a request together with a 16-bit vector address. The upper byte of that address comes from a programmable base register and the lower byte is the channel index times two. The coprocessor winner is presented as a request with its channel number. Each presented winner stays latched until its own acknowledge strobe arrives.

Top module: `irq_router`

## Requirements
- R1: After reset, both outputs are idle: `cpu_irq_o` and `cop_req_o` are 0. Every configuration entry is disabled with level 0 and CPU target.
- R2: A request line whose entry has its enable bit clear, or has level 0, is never forwarded to either target.
- R3: A CPU-routed line (target flag 0) is eligible only when its level is strictly greater than `cpu_mask_i`.
- R4: Among eligible lines for one target, the highest level wins. When levels are equal, the lowest channel index wins.
- R5: When the CPU request is raised, `cpu_vec_o` equals {`vbase_i` at that capture edge, 8-bit channel index × 2}. Bit 0 of the vector is always 0.
- R6: A coprocessor-routed line (target flag 1) is arbitrated independently of the CPU path and of `cpu_mask_i`. It is captured in the same cycle as any CPU winner, and `cop_chan_o` gives its index.
- R7: Once raised, an output request and its vector or channel stay unchanged until the matching acknowledge. This holds even if the request line drops or the configuration changes.
- R8: An acknowledge seen while the output is raised clears it on the next edge. A still-pending eligible line is captured again one edge later. An acknowledge while the output is idle has no effect.
- R9: A configuration write (`cfg_we_i`) updates entry `cfg_idx_i` at the clock edge. The new entry governs arbitration from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_REQ | Interrupt request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | CH_W | Entry index to write |
| cfg_en_i | input | 1 | Enable flag to write |
| cfg_lvl_i | input | 3 | Priority level to write |
| cfg_cop_i | input | 1 | Target to write (1 = coprocessor) |
| vbase_i | input | 8 | Vector base (high byte of vector) |
| cpu_mask_i | input | 3 | CPU interrupt priority mask |
| cpu_ack_i | input | 1 | CPU acknowledge |
| cop_ack_i | input | 1 | Coprocessor acknowledge |
| cpu_irq_o | output | 1 | CPU interrupt request |
| cpu_vec_o | output | 16 | CPU vector address |
| cop_req_o | output | 1 | Coprocessor request |
| cop_chan_o | output | CH_W | Coprocessor winning channel |

## Verification
The bench builds the router with eight channels, so the channel index is 3 bits wide. With that size, every channel, every level and every mask value is reached often during random stimulus. Ties between equal levels come up often enough to test the lowest-index rule. The highest vector low byte (0x0E) is exercised as well. Directed steps cover the cases that random stimulus rarely hits in a controlled way:
- a level exactly equal to the mask,
- a disabled line at top level,
- a re-capture right after an acknowledge.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_REQ = 16,
  parameter int CH_W  = $clog2(N_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             cfg_we_i,
  input  logic [CH_W-1:0]  cfg_idx_i,
  input  logic             cfg_en_i,
  input  logic [2:0]       cfg_lvl_i,
  input  logic             cfg_cop_i,
  input  logic [7:0]       vbase_i,
  input  logic [2:0]       cpu_mask_i,
  input  logic             cpu_ack_i,
  input  logic             cop_ack_i,
  output logic             cpu_irq_o,
  output logic [15:0]      cpu_vec_o,
  output logic             cop_req_o,
  output logic [CH_W-1:0]  cop_chan_o
);

  logic [N_REQ-1:0] en_q;
  logic [N_REQ-1:0] tgt_q;
  logic [2:0]       lvl_q [N_REQ];

  logic             cpu_hit, cop_hit;
  logic [2:0]       cpu_best, cop_best;
  logic [CH_W-1:0]  cpu_idx, cop_idx;

  for (genvar g = 0; g < N_REQ; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]  <= 1'b0;
        tgt_q[g] <= 1'b0;
        lvl_q[g] <= 3'd0;
      end else if (cfg_we_i && cfg_idx_i == CH_W'(g)) begin
        en_q[g]  <= cfg_en_i;
        tgt_q[g] <= cfg_cop_i;
        lvl_q[g] <= cfg_lvl_i;
      end
    end
  end

  always_comb begin
    cpu_hit  = 1'b0;
    cop_hit  = 1'b0;
    cpu_best = 3'd0;
    cop_best = 3'd0;
    cpu_idx  = '0;
    cop_idx  = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i] && en_q[i] && lvl_q[i] != 3'd0) begin
        if (!tgt_q[i] && lvl_q[i] > cpu_mask_i && lvl_q[i] >= cpu_best) begin
          cpu_hit  = 1'b1;
          cpu_best = lvl_q[i];
          cpu_idx  = CH_W'(i);
        end
        if (tgt_q[i] && lvl_q[i] >= cop_best) begin
          cop_hit  = 1'b1;
          cop_best = lvl_q[i];
          cop_idx  = CH_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq_o <= 1'b0;
      cpu_vec_o <= 16'h0000;
    end else if (cpu_irq_o) begin
      if (cpu_ack_i) cpu_irq_o <= 1'b0;
    end else if (cpu_hit) begin
      cpu_irq_o <= 1'b1;
      cpu_vec_o <= {vbase_i, 8'({cpu_idx, 1'b0})};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_req_o  <= 1'b0;
      cop_chan_o <= '0;
    end else if (cop_req_o) begin
      if (cop_ack_i) cop_req_o <= 1'b0;
    end else if (cop_hit) begin
      cop_req_o  <= 1'b1;
      cop_chan_o <= cop_idx;
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      vbase_i,
  input logic            cpu_ack_i,
  input logic            cop_ack_i,
  input logic            cpu_irq_o,
  input logic [15:0]     cpu_vec_o,
  input logic            cop_req_o,
  input logic [CH_W-1:0] cop_chan_o
);

  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o && !cpu_ack_i |=> cpu_irq_o && $stable(cpu_vec_o)); // R7
  AST_COP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cop_req_o && !cop_ack_i |=> cop_req_o && $stable(cop_chan_o)); // R7
  AST_CPU_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o && cpu_ack_i |=> !cpu_irq_o); // R8
  AST_COP_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cop_req_o && cop_ack_i |=> !cop_req_o); // R8
  AST_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> !cpu_vec_o[0]); // R5
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq_o ##1 cpu_irq_o |-> cpu_vec_o[15:8] == $past(vbase_i)); // R5

endmodule

bind irq_router irq_router_chk #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vbase_i(vbase_i),
  .cpu_ack_i(cpu_ack_i), .cop_ack_i(cop_ack_i),
  .cpu_irq_o(cpu_irq_o), .cpu_vec_o(cpu_vec_o),
  .cop_req_o(cop_req_o), .cop_chan_o(cop_chan_o)
);

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic we = 1'b0;
  logic [CW-1:0] widx = '0;
  logic wen = 1'b0;
  logic [2:0] wlvl = '0;
  logic wcop = 1'b0;
  logic [7:0] vbase = '0;
  logic [2:0] mask = '0;
  logic cack = 1'b0, pack = 1'b0;
  logic cirq, preq;
  logic [15:0] cvec;
  logic [CW-1:0] pchan;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router #(.N_REQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we_i(we), .cfg_idx_i(widx),
    .cfg_en_i(wen), .cfg_lvl_i(wlvl), .cfg_cop_i(wcop), .vbase_i(vbase),
    .cpu_mask_i(mask), .cpu_ack_i(cack), .cop_ack_i(pack),
    .cpu_irq_o(cirq), .cpu_vec_o(cvec), .cop_req_o(preq), .cop_chan_o(pchan));

  // behavioural reference
  bit m_en [N];
  int m_lvl [N];
  bit m_cop [N];
  bit m_cirq, m_preq;
  int m_vec, m_chan;

  function automatic int pick(bit cop_side);
    int best = 0, who = -1;
    for (int i = 0; i < N; i++)
      if (req[i] && m_en[i] && m_lvl[i] > 0 && m_cop[i] == cop_side &&
          (cop_side || m_lvl[i] > int'(mask)) && m_lvl[i] > best) begin
        best = m_lvl[i];
        who = i;
      end
    return who;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_lvl[i] = 0; m_cop[i] = 0; end
      m_cirq = 0; m_preq = 0; m_vec = 0; m_chan = 0;
    end else begin
      int wc, wp;
      wc = pick(1'b0);
      wp = pick(1'b1);
      if (m_cirq) begin if (cack) m_cirq = 0; end
      else if (wc >= 0) begin m_cirq = 1; m_vec = int'(vbase) * 256 + wc * 2; end
      if (m_preq) begin if (pack) m_preq = 0; end
      else if (wp >= 0) begin m_preq = 1; m_chan = wp; end
      if (we) begin m_en[widx] = wen; m_lvl[widx] = int'(wlvl); m_cop[widx] = wcop; end
    end
  end

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4/R7/R8 cpu_irq vs model", int'(cirq), int'(m_cirq));
      if (m_cirq) check("R5 cpu_vec vs model", int'(cvec), m_vec);
      check("R6/R7/R8 cop_req vs model", int'(preq), int'(m_preq));
      if (m_preq) check("R6 cop_chan vs model", int'(pchan), m_chan);
    end
  end

  task automatic wr(int idx, bit e, int l, bit c);
    @(negedge clk);
    we = 1; widx = CW'(idx); wen = e; wlvl = 3'(l); wcop = c;
    @(negedge clk);
    we = 0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cpu_irq after reset", int'(cirq), 0);
    check("R1 cop_req after reset", int'(preq), 0);
    req = '1;
    repeat (2) @(negedge clk);
    check("R2 all disabled, no cpu", int'(cirq), 0);
    check("R2 all disabled, no cop", int'(preq), 0);
    req = '0;
    wr(1, 1, 5, 0); wr(3, 1, 5, 0); wr(2, 1, 0, 0);
    wr(5, 0, 7, 0); wr(6, 1, 4, 1); wr(4, 1, 6, 1);
    vbase = 8'hA5; mask = 0;
    req = 8'b0111_1110;
    @(negedge clk);
    check("R4 tie to lowest index", int'(cvec), 16'hA502);
    check("R2 disabled ch5 skipped", int'(cirq), 1);
    check("R6 cop winner", int'(pchan), 4);
    req = '0; cack = 1; pack = 1; vbase = 8'h11;
    check("R7 vec held", int'(cvec), 16'hA502);
    @(negedge clk);
    check("R8 cpu cleared by ack", int'(cirq), 0);
    check("R8 cop cleared by ack", int'(preq), 0);
    cack = 0; pack = 0;
    mask = 5; req = 8'b0000_1010;
    @(negedge clk);
    check("R3 level equal to mask blocked", int'(cirq), 0);
    mask = 4;
    @(negedge clk);
    check("R3 level above mask passes", int'(cvec), 16'h1102);
    cack = 1; req = 8'b0000_1000;
    @(negedge clk);
    cack = 0;
    check("R8 idle cycle after ack", int'(cirq), 0);
    @(negedge clk);
    check("R8 recapture pending", int'(cvec), 16'h1106);
    cack = 1; req = '0;
    @(negedge clk);
    cack = 0;
    wr(3, 1, 2, 1);
    req = 8'b0000_1000;
    @(negedge clk);
    check("R9 rerouted to cop", int'(pchan), 3);
    check("R9 not on cpu", int'(cirq), 0);
    wr(7, 1, 7, 0);
    req = 8'b1000_0000; mask = 0;
    @(negedge clk);
    check("R5 top channel vector", int'(cvec), 16'h110E);
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      req = N'($urandom);
      cack = ($urandom % 3) == 0;
      pack = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) mask = 3'($urandom);
      if (($urandom % 32) == 0) vbase = 8'($urandom);
      we = ($urandom % 8) == 0;
      widx = CW'($urandom); wen = ($urandom % 4) != 0;
      wlvl = 3'($urandom); wcop = 1'($urandom);
    end
    @(negedge clk);
    we = 0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule